// File: doc/BRIEF.md
# Sprite Attribute Table Host Access Port

This block sits between a host register interface and the on-chip store that holds sprite attributes. The store has two parts: a low table of 256 sixteen-bit words (512 bytes) and a high table of 32 bytes. The host first loads a two-byte address register. It then streams bytes in or out through a single data register. Inside the block, a byte pointer is kept as a word address plus a byte-phase bit. The pointer advances on every accepted data byte.

Writes to the low table are paired. The first byte of a word waits in a holding latch, and the whole word is committed when its second byte arrives. Writes to the high table are committed one byte at a time. When vertical blank starts and forced blank is off, the pointer is reloaded from the address register. A rotation bit in the address register makes the block produce a first-sprite index for the renderer. The renderer also gets its own read ports into both tables, each with one cycle of read latency.

Top module: `sat_access_port`

## Requirements
- R1: In the cycle after synchronous reset, `first_sprite` and `host_rdata` are 0 and the byte pointer is 0.
- R2: A host write with `host_sel`=0 loads the address low byte, and one with `host_sel`=1 loads the address high byte. Either write sets the byte pointer to word address {high[0], low} with phase 0. Bit 0 of the high byte set means the high table.
- R3: In the low table, a data write (`host_sel`=2) at phase 0 only latches the byte. The write at phase 1 stores the word {this byte, latched byte} at word address bits [7:0].
- R4: In the high table, every data write stores its byte at pointer bits [4:0]. The pointer then increments within those five bits and wraps from 31 to 0, leaving the upper bits unchanged.
- R5: Each accepted data byte in the low table advances the byte pointer by one. After the second byte of word 255, the next byte goes to high-table byte 0.
- R6: An accepted data read (`host_rd` with `host_sel`=2) shows the addressed byte on `host_rdata` one cycle later and advances the pointer as a write would. In the low table, phase 0 returns bits [7:0] of the word and phase 1 returns bits [15:8]. `host_rdata` holds its value between reads.
- R7: On the first cycle of `vblank` high, with `force_blank` low, the pointer is reloaded from the address register with phase 0. With `force_blank` high no reload happens.
- R8: A data access while both `vblank` and `force_blank` are low is ignored. Nothing is stored, the pointer does not move and `host_rdata` is unchanged. Address register writes are always accepted.
- R9: When address high bit 7 is 0, `first_sprite` is 0. When it is 1, `first_sprite` takes word-address bits [7:1] on each address load, each reload, and each accepted data access. For a data access it uses the address accessed before the increment.
- R10: `rnd_lo_data` and `rnd_hi_data` return the table contents at the addresses presented one cycle earlier. A same-cycle host write is not yet visible.
- R11: A data access in the cycle in which a vertical-blank reload happens is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Register select: 0 address low, 1 address high, 2 data |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Byte returned by the last accepted data read |
| vblank | input | 1 | Vertical blank level |
| force_blank | input | 1 | Forced blank level |
| rnd_lo_addr | input | 8 | Renderer low-table word address |
| rnd_lo_data | output | 16 | Renderer low-table word |
| rnd_hi_addr | input | 5 | Renderer high-table byte address |
| rnd_hi_data | output | 8 | Renderer high-table byte |
| first_sprite | output | 7 | First-sprite priority index |

## Verification
The assertions assume that `host_wr` and `host_rd` are never high in the same cycle. They also assume that a reload is checked only in a cycle with no address write. The stimulus drives one host strobe per cycle. Each `vblank` rise is scheduled either alone or, on purpose, together with a single data write to exercise R11. Renderer reads are compared only against table entries the stimulus has already written, since the storage is not initialised.

// File: rtl/sat_pkg.sv
package sat_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_DATA    = 2'd2,
    SEL_NONE    = 2'd3
  } sat_sel_e;
endpackage

// File: rtl/sat_dpram.sv
module sat_dpram #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    b_rdata <= mem[b_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)       a_rdata <= '0;
    else if (a_re) a_rdata <= mem[a_addr];
  end
endmodule

// File: rtl/sat_pair_latch.sv
module sat_pair_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (hold_en) held <= din;
  end
endmodule

// File: rtl/sat_addr_ctrl.sv
module sat_addr_ctrl
  import sat_pkg::*;
#(
  parameter int LO_AW   = 8,
  parameter int HI_AW   = 5,
  parameter int ROT_BIT = 7,
  localparam int PW     = LO_AW + 2,
  localparam int FS_W   = LO_AW - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              vblank,
  input  logic              force_blank,
  output logic [PW-1:0]     ptr,
  output logic              hold_en,
  output logic              lo_we,
  output logic              lo_re,
  output logic              hi_we,
  output logic              hi_re,
  output logic              reload,
  output logic [BYTE_W-1:0] addr_lo,
  output logic [BYTE_W-1:0] addr_hi,
  output logic [FS_W-1:0]   first_sprite
);
  sat_sel_e sel;
  logic vb_q, window, addr_wr, acc_ok, data_wr, data_rd, data_go, in_hi;
  logic [BYTE_W-1:0] lo_n, hi_n;
  logic [PW-1:0] load_val, ptr_inc;
  logic [HI_AW-1:0] hi_next;

  assign sel     = sat_sel_e'(host_sel);
  assign window  = vblank | force_blank;
  assign reload  = vblank & ~vb_q & ~force_blank;
  assign addr_wr = host_wr & (sel == SEL_ADDR_LO || sel == SEL_ADDR_HI);
  assign data_wr = host_wr & (sel == SEL_DATA);
  assign data_rd = host_rd & ~host_wr & (sel == SEL_DATA);
  assign acc_ok  = window & ~reload & ~addr_wr;
  assign data_go = (data_wr | data_rd) & acc_ok;
  assign in_hi   = ptr[PW-1];

  assign hold_en = data_wr & acc_ok & ~in_hi & ~ptr[0];
  assign lo_we   = data_wr & acc_ok & ~in_hi &  ptr[0];
  assign hi_we   = data_wr & acc_ok &  in_hi;
  assign lo_re   = data_rd & acc_ok & ~in_hi;
  assign hi_re   = data_rd & acc_ok &  in_hi;

  always_comb begin
    lo_n = addr_lo;
    hi_n = addr_hi;
    if (host_wr && sel == SEL_ADDR_LO) lo_n = host_wdata;
    if (host_wr && sel == SEL_ADDR_HI) hi_n = host_wdata;
  end

  assign load_val = {hi_n[0], lo_n, 1'b0};
  assign hi_next  = ptr[HI_AW-1:0] + 1'b1;
  assign ptr_inc  = in_hi ? {ptr[PW-1:HI_AW], hi_next} : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      vb_q         <= 1'b0;
      addr_lo      <= '0;
      addr_hi      <= '0;
      ptr          <= '0;
      first_sprite <= '0;
    end else begin
      vb_q    <= vblank;
      addr_lo <= lo_n;
      addr_hi <= hi_n;
      if (addr_wr || reload) begin
        ptr          <= load_val;
        first_sprite <= hi_n[ROT_BIT] ? load_val[LO_AW:2] : '0;
      end else if (data_go) begin
        ptr          <= ptr_inc;
        first_sprite <= addr_hi[ROT_BIT] ? ptr[LO_AW:2] : '0;
      end
    end
  end
endmodule

// File: rtl/sat_access_port.sv
module sat_access_port
  import sat_pkg::*;
#(
  parameter int LO_WORDS = 256,
  parameter int HI_BYTES = 32,
  parameter int ROT_BIT  = 7,
  localparam int LO_AW   = $clog2(LO_WORDS),
  localparam int HI_AW   = $clog2(HI_BYTES),
  localparam int FS_W    = LO_AW - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [1:0]        host_sel,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              vblank,
  input  logic              force_blank,
  input  logic [LO_AW-1:0]  rnd_lo_addr,
  output logic [15:0]       rnd_lo_data,
  input  logic [HI_AW-1:0]  rnd_hi_addr,
  output logic [7:0]        rnd_hi_data,
  output logic [FS_W-1:0]   first_sprite
);
  localparam int PW = LO_AW + 2;

  logic [PW-1:0] ptr;
  logic hold_en, lo_we, lo_re, hi_we, hi_re, reload;
  logic [BYTE_W-1:0] addr_lo, addr_hi, held, hi_q;
  logic [2*BYTE_W-1:0] lo_q;
  logic rd_from_hi, rd_upper;

  sat_addr_ctrl #(.LO_AW(LO_AW), .HI_AW(HI_AW), .ROT_BIT(ROT_BIT)) u_ctrl (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .vblank(vblank),
    .force_blank(force_blank), .ptr(ptr), .hold_en(hold_en),
    .lo_we(lo_we), .lo_re(lo_re), .hi_we(hi_we), .hi_re(hi_re),
    .reload(reload), .addr_lo(addr_lo), .addr_hi(addr_hi),
    .first_sprite(first_sprite)
  );

  sat_pair_latch #(.W(BYTE_W)) u_hold (
    .clk(clk), .rst(rst), .hold_en(hold_en), .din(host_wdata), .held(held)
  );

  sat_dpram #(.AW(LO_AW), .DW(2*BYTE_W)) u_lo_ram (
    .clk(clk), .rst(rst), .a_we(lo_we), .a_re(lo_re),
    .a_addr(ptr[LO_AW:1]), .a_wdata({host_wdata, held}), .a_rdata(lo_q),
    .b_addr(rnd_lo_addr), .b_rdata(rnd_lo_data)
  );

  sat_dpram #(.AW(HI_AW), .DW(BYTE_W)) u_hi_ram (
    .clk(clk), .rst(rst), .a_we(hi_we), .a_re(hi_re),
    .a_addr(ptr[HI_AW-1:0]), .a_wdata(host_wdata), .a_rdata(hi_q),
    .b_addr(rnd_hi_addr), .b_rdata(rnd_hi_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_from_hi <= 1'b0;
      rd_upper   <= 1'b0;
    end else if (lo_re || hi_re) begin
      rd_from_hi <= hi_re;
      rd_upper   <= ptr[0];
    end
  end

  always_comb begin
    if (rd_from_hi)    host_rdata = hi_q;
    else if (rd_upper) host_rdata = lo_q[2*BYTE_W-1:BYTE_W];
    else               host_rdata = lo_q[BYTE_W-1:0];
  end
endmodule

// File: rtl/sat_access_checker.sv
module sat_access_checker
  import sat_pkg::*;
#(
  parameter int PW      = 10,
  parameter int HI_AW   = 5,
  parameter int FS_W    = 7,
  parameter int ROT_BIT = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              host_wr,
  input logic              host_rd,
  input logic [1:0]        host_sel,
  input logic              vblank,
  input logic              force_blank,
  input logic [PW-1:0]     ptr,
  input logic              lo_we,
  input logic              lo_re,
  input logic              hi_we,
  input logic              hi_re,
  input logic [BYTE_W-1:0] addr_lo,
  input logic [BYTE_W-1:0] addr_hi,
  input logic [FS_W-1:0]   first_sprite
);
  logic addr_wr;
  assign addr_wr = host_wr && (host_sel == 2'd0 || host_sel == 2'd1);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (first_sprite == '0 && ptr == '0)); // R1

  AST_LO_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (lo_we || lo_re) |=> ptr == $past(ptr) + 1'b1); // R5

  AST_HI_WRAP: assert property (@(posedge clk) disable iff (rst)
    (hi_we || hi_re) |=> (ptr[PW-1:HI_AW] == $past(ptr[PW-1:HI_AW]) &&
      ptr[HI_AW-1:0] == HI_AW'($past(ptr[HI_AW-1:0]) + 1'b1))); // R4

  AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((host_wr || host_rd) && host_sel == 2'd2 && !vblank && !force_blank)
      |=> $stable(ptr)); // R8

  AST_VB_RELOAD: assert property (@(posedge clk) disable iff (rst)
    ($rose(vblank) && !force_blank && !addr_wr)
      |=> ptr == {addr_hi[0], addr_lo, 1'b0}); // R7

  AST_ROT_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    !addr_hi[ROT_BIT] |-> first_sprite == '0); // R9
endmodule

bind sat_access_port sat_access_checker #(
  .PW(PW), .HI_AW(HI_AW), .FS_W(FS_W), .ROT_BIT(ROT_BIT)
) u_chk (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_sel(host_sel), .vblank(vblank), .force_blank(force_blank),
  .ptr(ptr), .lo_we(lo_we), .lo_re(lo_re), .hi_we(hi_we), .hi_re(hi_re),
  .addr_lo(addr_lo), .addr_hi(addr_hi), .first_sprite(first_sprite)
);

// File: tb/sat_access_port_bench.sv
module sat_access_port_bench;
  logic clk = 0, rst = 1;
  logic host_wr = 0, host_rd = 0;
  logic [1:0] host_sel = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic vblank = 0, force_blank = 1;
  logic [7:0] rnd_lo_addr = 0;
  logic [15:0] rnd_lo_data;
  logic [4:0] rnd_hi_addr = 0;
  logic [7:0] rnd_hi_data;
  logic [6:0] first_sprite;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  sat_access_port u_sat_access_port (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .vblank(vblank), .force_blank(force_blank), .rnd_lo_addr(rnd_lo_addr),
    .rnd_lo_data(rnd_lo_data), .rnd_hi_addr(rnd_hi_addr),
    .rnd_hi_data(rnd_hi_data), .first_sprite(first_sprite)
  );

  always #4 clk = ~clk;

  // behavioural reference model
  bit [7:0] lo_b [512];
  bit       lo_v [512];
  bit [7:0] hi_b [32];
  bit       hi_v [32];
  int m_ptr, m_alo, m_ahi, m_fs;
  bit [7:0] m_latch, e_rd;
  bit e_rd_v, m_vbq;
  bit [15:0] e_lo;
  bit [7:0] e_hi;
  bit e_lo_v, e_hi_v;

  always @(posedge clk) begin
    if (rst) begin
      m_ptr = 0; m_alo = 0; m_ahi = 0; m_fs = 0; m_latch = 0;
      e_rd = 0; e_rd_v = 1; m_vbq = 0; e_lo_v = 0; e_hi_v = 0;
    end else begin
      bit rl, aw;
      e_lo   = {lo_b[2*rnd_lo_addr+1], lo_b[2*rnd_lo_addr]};
      e_lo_v = lo_v[2*rnd_lo_addr+1] && lo_v[2*rnd_lo_addr];
      e_hi   = hi_b[rnd_hi_addr];
      e_hi_v = hi_v[rnd_hi_addr];
      rl = vblank && !m_vbq && !force_blank;
      m_vbq = vblank;
      aw = host_wr && (host_sel == 0 || host_sel == 1);
      if (host_wr && host_sel == 0) m_alo = host_wdata;
      if (host_wr && host_sel == 1) m_ahi = host_wdata;
      if (aw || rl) begin
        m_ptr = (((m_ahi & 1) << 8) | m_alo) * 2;
        m_fs = (m_ahi & 8'h80) != 0 ? (m_ptr >> 2) & 127 : 0;
      end else if ((vblank || force_blank) && host_sel == 2 && (host_wr || host_rd)) begin
        m_fs = (m_ahi & 8'h80) != 0 ? (m_ptr >> 2) & 127 : 0;
        if (host_wr) begin
          if (m_ptr < 512) begin
            if (m_ptr % 2 == 0) m_latch = host_wdata;
            else begin
              lo_b[m_ptr-1] = m_latch; lo_b[m_ptr] = host_wdata;
              lo_v[m_ptr-1] = 1; lo_v[m_ptr] = 1;
            end
          end else begin
            hi_b[m_ptr % 32] = host_wdata; hi_v[m_ptr % 32] = 1;
          end
        end else begin
          e_rd   = m_ptr < 512 ? lo_b[m_ptr] : hi_b[m_ptr % 32];
          e_rd_v = m_ptr < 512 ? lo_v[m_ptr] : hi_v[m_ptr % 32];
        end
        m_ptr = m_ptr < 512 ? m_ptr + 1 : (m_ptr & ~31) | ((m_ptr + 1) & 31);
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (first_sprite !== 7'(m_fs)) begin
        fails++;
        $display("FAIL %s/R9 first_sprite actual %h expected %h", cur_req, first_sprite, 7'(m_fs));
      end
      if (e_rd_v) begin
        checks++;
        if (host_rdata !== e_rd) begin
          fails++;
          $display("FAIL %s/R6 host_rdata actual %h expected %h", cur_req, host_rdata, e_rd);
        end
      end
      if (e_lo_v) begin
        checks++;
        if (rnd_lo_data !== e_lo) begin
          fails++;
          $display("FAIL %s/R10 rnd_lo_data actual %h expected %h", cur_req, rnd_lo_data, e_lo);
        end
      end
      if (e_hi_v) begin
        checks++;
        if (rnd_hi_data !== e_hi) begin
          fails++;
          $display("FAIL %s/R10 rnd_hi_data actual %h expected %h", cur_req, rnd_hi_data, e_hi);
        end
      end
    end
  end

  task automatic op(input bit wr, input bit rd, input bit [1:0] sel, input bit [7:0] d);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_sel = sel; host_wdata = d;
  endtask
  task automatic idle(); op(0, 0, 3, 0); endtask
  task automatic set_addr(input bit [7:0] lo, input bit [7:0] hi);
    op(1, 0, 0, lo); op(1, 0, 1, hi);
  endtask
  task automatic wr(input bit [7:0] d); op(1, 0, 2, d); endtask
  task automatic rd(); op(0, 1, 2, 0); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;
    if (first_sprite !== 0 || host_rdata !== 0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %h/%h expected 00/00", first_sprite, host_rdata);
    end

    cur_req = "R3";
    set_addr(8'h10, 8'h00); rnd_lo_addr = 8'h10;
    wr(8'hAA); idle(); wr(8'hBB); idle(); idle();
    set_addr(8'h10, 8'h00); wr(8'h77); idle(); idle(); idle();

    cur_req = "R2";
    set_addr(8'h20, 8'h00); wr(8'h01); wr(8'h02);
    op(1, 0, 0, 8'h30); wr(8'h03); wr(8'h04); rnd_lo_addr = 8'h30;
    op(1, 0, 0, 8'h40); wr(8'h9C); op(1, 0, 1, 8'h00);
    wr(8'h05); wr(8'h06); rnd_lo_addr = 8'h40; idle(); idle();

    cur_req = "R5";
    set_addr(8'hFF, 8'h00); rnd_lo_addr = 8'hFF;
    wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
    idle(); rnd_hi_addr = 5'd1; idle(); idle();

    cur_req = "R4";
    set_addr(8'h00, 8'h01);
    for (int i = 0; i < 34; i++) wr(8'(8'h40 + i));
    for (int i = 0; i < 32; i++) begin idle(); rnd_hi_addr = 5'(i); end
    idle(); idle();

    cur_req = "R6";
    set_addr(8'h10, 8'h00);
    rd(); idle(); rd(); rd(); rd(); idle(); idle();
    set_addr(8'h1F, 8'h01);
    rd(); rd(); rd(); idle(); idle(); idle();

    cur_req = "R10";
    foreach (lo_v[i]) if (i % 2 == 0 && i < 512 && lo_v[i]) begin
      idle(); rnd_lo_addr = 8'(i / 2);
    end
    idle(); idle();

    cur_req = "R9";
    set_addr(8'h24, 8'h80);
    wr(8'h10); wr(8'h20); wr(8'h30); wr(8'h40); rd(); rd(); idle();
    set_addr(8'hFE, 8'h81); wr(8'h55); idle();
    op(1, 0, 1, 8'h00); idle(); wr(8'h66); idle(); idle();

    cur_req = "R7";
    set_addr(8'h50, 8'h00); wr(8'h01); wr(8'h02); idle();
    force_blank = 0; vblank = 1;
    wr(8'h11); wr(8'h22); rnd_lo_addr = 8'h50; idle();
    vblank = 0; force_blank = 1;
    wr(8'h33); wr(8'h44); idle();
    vblank = 1;
    wr(8'h55); wr(8'h66); rnd_lo_addr = 8'h51; idle(); rnd_lo_addr = 8'h52; idle(); idle();

    cur_req = "R11";
    vblank = 0; force_blank = 0;
    set_addr(8'h60, 8'h00); idle();
    wr(8'h99); vblank = 1;
    wr(8'h01); wr(8'h02); rnd_lo_addr = 8'h60; idle(); idle(); idle();

    cur_req = "R8";
    vblank = 0; force_blank = 0;
    set_addr(8'h70, 8'h00);
    wr(8'hAA); wr(8'hBB); rd(); idle(); idle();
    force_blank = 1;
    wr(8'h01); wr(8'h02); rnd_lo_addr = 8'h70; idle(); idle(); idle();
    rd(); rd(); idle(); idle();

    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule